// File: doc/BRIEF.md
# Zoned TLB Lookup

This block is the search stage of a translation lookaside buffer. Each of its entries holds a tag word, a data word and an 8-bit translation ID, and each entry covers a page whose size it chooses itself, from 1 KiB up to 16 MiB. A lookup gives a virtual address, an access kind (read, write or fetch) and a flag that marks the access as user mode. Every entry is checked at once against the address, the process ID and the zone protection word. The lowest-numbered entry that claims the access decides the result.

The result is a hit, a miss or a protection fault. It carries the index of the deciding entry and, on a hit, the real page number and the size code. The search logic is combinational. The result is captured into registers on the clock edge where the lookup strobe is sampled high, and it is then held until the next lookup. Entries are loaded through a plain write port. A tag write also stores the translation ID presented alongside it.

Top module: `zonedTlbLookup`

## Requirements
- R1: Reset clears every entry, so none of them is valid. It also clears all result outputs to zero, including `resValid`.
- R2: When `lookupReq` is sampled high at a clock edge, the result outputs take that lookup's outcome at that same edge, and `resValid` is high for exactly that cycle. With no request, the result outputs keep their values and exactly one of `resHit`, `resMiss` and `resFault` stays high after the first lookup.
- R3: With `wrEn` high, `wrSel`=0 writes `wrData` into the tag word of entry `wrIdx` and stores `wrTid` as that entry's translation ID. `wrSel`=1 writes the data word. The tag layout is page number in [31:10], size code in [9:7] and valid in bit 6. Writing a tag with bit 6 clear removes the entry from the search.
- R4: Size codes 0 to 7 select 1 KiB, 4 KiB, 16 KiB, 64 KiB, 256 KiB, 1 MiB, 4 MiB and 16 MiB. The address and the tag page number are compared only above the page size.
- R5: An entry whose translation ID is 0 matches any `procId`. Any other ID must equal `procId`.
- R6: An entry claims a lookup when it is valid, its address matches, its ID matches and it is not hidden under R9. The lowest-numbered claiming entry decides the result. On a hit, `resIdx` is its index, `resRpn` is its data bits [31:10] and `resSize` is its size code.
- R7: If no entry claims the lookup, `resMiss` is set and `resIdx`, `resRpn` and `resSize` are zero.
- R8: The data word holds execute-enable in bit 9, write-enable in bit 8 and the zone select in [7:4]. The 2-bit code for zone z is read from `zoneReg` bits [31-2z:30-2z].
- R9: Zone code 0 hides the entry from user accesses, so the search passes on to higher entries. For privileged accesses it behaves like code 1, which applies the entry's own enable bits unchanged.
- R10: Zone code 2 grants write and execute to privileged accesses and leaves user accesses to the entry's own bits. Zone code 3 grants write and execute to every access.
- R11: A zone select greater than the parameter ZONE_LIMIT (default 11) is treated as zone code 1. A select equal to ZONE_LIMIT uses its field in `zoneReg`.
- R12: A read (kind 0, and kind 3, which is handled as a read) is always permitted. A write (kind 1) without effective write permission, or a fetch (kind 2) without effective execute permission, gives `resFault`. In that case `resIdx` is the deciding entry and `resRpn` and `resSize` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Entry write strobe |
| wrSel | input | 1 | 0 selects the tag word, 1 selects the data word |
| wrIdx | input | 6 | Entry index for the write |
| wrData | input | 32 | Word to be written |
| wrTid | input | 8 | Translation ID stored with a tag write |
| procId | input | 8 | Current process ID |
| zoneReg | input | 32 | Zone protection word, 2 bits per zone |
| lookupReq | input | 1 | Lookup strobe |
| lookupVa | input | 32 | Virtual address to translate |
| lookupKind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| lookupUser | input | 1 | 1 for a user-mode access |
| resValid | output | 1 | High in the cycle a new result appears |
| resHit | output | 1 | Translation found and permitted |
| resMiss | output | 1 | No entry claimed the lookup |
| resFault | output | 1 | Deciding entry denied the access |
| resIdx | output | 6 | Index of the deciding entry |
| resRpn | output | 22 | Real page number on a hit |
| resSize | output | 3 | Page size code on a hit |

## Verification
The bench sweeps all eight page sizes and probes one word inside and one word past each page boundary. A mask built off by one size step would hit past the end or miss inside the page. It sets up overlapping entries so that priority is visible, and it invalidates the winner to show that the next entry takes over. It puts zone code 0 under a user access so that a lower entry must be skipped rather than fault. Zone selects equal to and just above the limit separate a limit compare written as greater-or-equal from the correct one, and a zone field read at a mirrored bit position would grant or deny the wrong accesses. A randomized phase mixes translation IDs, zone words and access kinds, and the bench compares the outputs against its own model on every cycle.

// File: rtl/tlbPkg.sv
package tlbPkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned TID_W     = 8;
  localparam int unsigned PAGE_LSB  = 10;
  localparam int unsigned VPN_W     = WORD_W - PAGE_LSB;
  localparam int unsigned SIZE_W    = 3;
  localparam int unsigned SIZE_LSB  = 7;
  localparam int unsigned VALID_BIT = 6;
  localparam int unsigned EX_BIT    = 9;
  localparam int unsigned WR_BIT    = 8;
  localparam int unsigned ZSEL_W    = 4;
  localparam int unsigned ZSEL_LSB  = 4;
  localparam int unsigned ZCODE_W   = 2;

  typedef enum logic [1:0] {
    ACC_READ   = 2'd0,
    ACC_WRITE  = 2'd1,
    ACC_FETCH  = 2'd2,
    ACC_READ_B = 2'd3
  } accKind_t;

  typedef enum logic [1:0] {
    ZONE_NOUSER    = 2'd0,
    ZONE_PAGE      = 2'd1,
    ZONE_PRIV_FULL = 2'd2,
    ZONE_ALL_FULL  = 2'd3
  } zoneCode_t;

  typedef struct packed {
    logic tagWrite;
    logic dataWrite;
    logic capture;
  } tlbStrobe_t;

endpackage

// File: rtl/tlbEntry.sv
module tlbEntry
  import tlbPkg::*;
#(
  parameter int unsigned ZONE_LIMIT = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tagWe,
  input  logic              dataWe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [TID_W-1:0]  wrTid,
  input  logic [VPN_W-1:0]  vpn,
  input  logic              user,
  input  accKind_t          kind,
  input  logic [TID_W-1:0]  procId,
  input  logic [WORD_W-1:0] zoneReg,
  output logic              claim,
  output logic              permit,
  output logic [VPN_W-1:0]  rpn,
  output logic [SIZE_W-1:0] sizeCode
);

  logic [WORD_W-1:0] tagQ;
  logic [WORD_W-1:0] dataQ;
  logic [TID_W-1:0]  tidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagQ  <= '0;
      dataQ <= '0;
      tidQ  <= '0;
    end else begin
      if (tagWe) begin
        tagQ <= wrData;
        tidQ <= wrTid;
      end
      if (dataWe) begin
        dataQ <= wrData;
      end
    end
  end

  // Page compare: clear the low 2*size bits of the page-number field.
  logic [VPN_W-1:0] pageMask;
  logic             addrMatch;
  logic             tidMatch;

  assign sizeCode  = tagQ[SIZE_LSB +: SIZE_W];
  assign pageMask  = {VPN_W{1'b1}} << {sizeCode, 1'b0};
  assign addrMatch = ((vpn ^ tagQ[PAGE_LSB +: VPN_W]) & pageMask) == '0;
  assign tidMatch  = (tidQ == '0) || (tidQ == procId);

  // Zone code lookup: zone z sits at bit offset 30 - 2z.
  logic [ZSEL_W-1:0] zoneSel;
  logic [4:0]        zoneShift;
  logic [WORD_W-1:0] zoneField;
  zoneCode_t         zoneCode;

  assign zoneSel   = dataQ[ZSEL_LSB +: ZSEL_W];
  assign zoneShift = 5'd30 - {zoneSel, 1'b0};
  assign zoneField = zoneReg >> zoneShift;

  always_comb begin
    if (32'(zoneSel) > ZONE_LIMIT) begin
      zoneCode = ZONE_PAGE;
    end else begin
      zoneCode = zoneCode_t'(zoneField[ZCODE_W-1:0]);
    end
  end

  logic wrEff;
  logic exEff;
  logic hidden;

  always_comb begin
    wrEff = dataQ[WR_BIT];
    exEff = dataQ[EX_BIT];
    case (zoneCode)
      ZONE_PRIV_FULL: begin
        if (!user) begin
          wrEff = 1'b1;
          exEff = 1'b1;
        end
      end
      ZONE_ALL_FULL: begin
        wrEff = 1'b1;
        exEff = 1'b1;
      end
      default: ;
    endcase
  end

  assign hidden = (zoneCode == ZONE_NOUSER) && user;
  assign claim  = tagQ[VALID_BIT] && addrMatch && tidMatch && !hidden;

  always_comb begin
    case (kind)
      ACC_WRITE: permit = wrEff;
      ACC_FETCH: permit = exEff;
      default:   permit = 1'b1;
    endcase
  end

  assign rpn = dataQ[PAGE_LSB +: VPN_W];

  logic unusedEntryBits;
  assign unusedEntryBits = ^{tagQ[VALID_BIT-1:0], dataQ[ZSEL_LSB-1:0],
                             zoneField[WORD_W-1:ZCODE_W]};

endmodule

// File: rtl/tlbCtrl.sv
module tlbCtrl
  import tlbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic       lookupReq,
  output tlbStrobe_t strobe,
  output logic       resValid
);

  always_comb begin
    strobe.tagWrite  = wrEn && !wrSel;
    strobe.dataWrite = wrEn && wrSel;
    strobe.capture   = lookupReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
    end else begin
      resValid <= lookupReq;
    end
  end

endmodule

// File: rtl/tlbDatapath.sv
module tlbDatapath
  import tlbPkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64,
  parameter int unsigned ZONE_LIMIT  = 11,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [WORD_W-1:0] wrData,
  input  logic [TID_W-1:0]  wrTid,
  input  logic [VPN_W-1:0]  vpn,
  input  logic              user,
  input  accKind_t          kind,
  input  logic [TID_W-1:0]  procId,
  input  logic [WORD_W-1:0] zoneReg,
  output logic              resHit,
  output logic              resMiss,
  output logic              resFault,
  output logic [IDX_W-1:0]  resIdx,
  output logic [VPN_W-1:0]  resRpn,
  output logic [SIZE_W-1:0] resSize
);

  logic [NUM_ENTRIES-1:0] claimVec;
  logic [NUM_ENTRIES-1:0] permitVec;
  logic [VPN_W-1:0]       entRpn  [NUM_ENTRIES];
  logic [SIZE_W-1:0]      entSize [NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gEntry
    tlbEntry #(
      .ZONE_LIMIT(ZONE_LIMIT)
    ) u_entry (
      .clk     (clk),
      .rstN    (rstN),
      .tagWe   (strobe.tagWrite && (wrIdx == IDX_W'(e))),
      .dataWe  (strobe.dataWrite && (wrIdx == IDX_W'(e))),
      .wrData  (wrData),
      .wrTid   (wrTid),
      .vpn     (vpn),
      .user    (user),
      .kind    (kind),
      .procId  (procId),
      .zoneReg (zoneReg),
      .claim   (claimVec[e]),
      .permit  (permitVec[e]),
      .rpn     (entRpn[e]),
      .sizeCode(entSize[e])
    );
  end

  // Lowest-numbered claimant wins: scan downward so the last write is lowest.
  logic             found;
  logic [IDX_W-1:0] winIdx;

  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (claimVec[i]) begin
        found  = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

  logic winPermit;
  assign winPermit = permitVec[winIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resHit   <= 1'b0;
      resMiss  <= 1'b0;
      resFault <= 1'b0;
      resIdx   <= '0;
      resRpn   <= '0;
      resSize  <= '0;
    end else if (strobe.capture) begin
      resHit   <= found && winPermit;
      resMiss  <= !found;
      resFault <= found && !winPermit;
      resIdx   <= found ? winIdx : '0;
      resRpn   <= (found && winPermit) ? entRpn[winIdx] : '0;
      resSize  <= (found && winPermit) ? entSize[winIdx] : '0;
    end
  end

  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    resMiss |-> (resIdx == '0 && resRpn == '0 && resSize == '0)); // R7

  AST_READ_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && (kind == ACC_READ || kind == ACC_READ_B)) |=> !resFault); // R12

  AST_FAULT_NO_PAYLOAD: assert property (@(posedge clk) disable iff (!rstN)
    resFault |-> (resRpn == '0 && resSize == '0)); // R12

endmodule

// File: rtl/zonedTlbLookup.sv
module zonedTlbLookup
  import tlbPkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64,
  parameter int unsigned ZONE_LIMIT  = 11,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [WORD_W-1:0] wrData,
  input  logic [TID_W-1:0]  wrTid,
  input  logic [TID_W-1:0]  procId,
  input  logic [WORD_W-1:0] zoneReg,
  input  logic              lookupReq,
  input  logic [WORD_W-1:0] lookupVa,
  input  logic [1:0]        lookupKind,
  input  logic              lookupUser,
  output logic              resValid,
  output logic              resHit,
  output logic              resMiss,
  output logic              resFault,
  output logic [IDX_W-1:0]  resIdx,
  output logic [VPN_W-1:0]  resRpn,
  output logic [SIZE_W-1:0] resSize
);

  tlbStrobe_t strobe;

  tlbCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .lookupReq(lookupReq),
    .strobe   (strobe),
    .resValid (resValid)
  );

  tlbDatapath #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ZONE_LIMIT (ZONE_LIMIT)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrIdx   (wrIdx),
    .wrData  (wrData),
    .wrTid   (wrTid),
    .vpn     (lookupVa[WORD_W-1:PAGE_LSB]),
    .user    (lookupUser),
    .kind    (accKind_t'(lookupKind)),
    .procId  (procId),
    .zoneReg (zoneReg),
    .resHit  (resHit),
    .resMiss (resMiss),
    .resFault(resFault),
    .resIdx  (resIdx),
    .resRpn  (resRpn),
    .resSize (resSize)
  );

  logic unusedVaLow;
  assign unusedVaLow = ^lookupVa[PAGE_LSB-1:0];

  AST_OUTCOME_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    lookupReq |=> (resValid && $countones({resHit, resMiss, resFault}) == 1)); // R2

  AST_HELD_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !lookupReq |=> $stable({resHit, resMiss, resFault, resIdx, resRpn, resSize})); // R2

endmodule

// File: tb/zonedTlbLookup_bench.sv
module zonedTlbLookup_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [5:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  wrTid = '0;
  logic [7:0]  procId = '0;
  logic [31:0] zoneReg = 32'h5555_5555;
  logic        lookupReq = 1'b0;
  logic [31:0] lookupVa = '0;
  logic [1:0]  lookupKind = '0;
  logic        lookupUser = 1'b0;
  logic        resValid, resHit, resMiss, resFault;
  logic [5:0]  resIdx;
  logic [21:0] resRpn;
  logic [2:0]  resSize;

  always #10 clk = ~clk;

  zonedTlbLookup u_zonedTlbLookup (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx),
    .wrData(wrData), .wrTid(wrTid), .procId(procId), .zoneReg(zoneReg),
    .lookupReq(lookupReq), .lookupVa(lookupVa), .lookupKind(lookupKind),
    .lookupUser(lookupUser), .resValid(resValid), .resHit(resHit),
    .resMiss(resMiss), .resFault(resFault), .resIdx(resIdx),
    .resRpn(resRpn), .resSize(resSize)
  );

  int    checks = 0;
  int    fails = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  // Reference state kept by the bench.
  logic [31:0] mTag  [64];
  logic [31:0] mData [64];
  logic [7:0]  mTid  [64];
  logic        eValid, eHit, eMiss, eFault;
  logic [5:0]  eIdx;
  logic [21:0] eRpn;
  logic [2:0]  eSize;

  function automatic void refLookup(
    input  logic [31:0] va, input logic [1:0] kind, input logic usr,
    input  logic [7:0] pid, input logic [31:0] zr,
    output logic h, output logic m, output logic f,
    output logic [5:0] ix, output logic [21:0] rp, output logic [2:0] sz);
    h = 0; m = 1; f = 0; ix = 0; rp = 0; sz = 0;
    for (int i = 0; i < 64; i++) begin
      logic [31:0] t, d, msk;
      longint      bytes;
      int          z, code;
      bit          wrOk, exOk;
      t = mTag[i];
      d = mData[i];
      if (!t[6]) continue;
      bytes = 64'd1024 << (2 * t[9:7]);
      msk = ~(32'(bytes) - 32'd1);
      if ((va & msk) != (t & msk)) continue;
      if (mTid[i] != 0 && mTid[i] != pid) continue;
      z = int'(d[7:4]);
      code = (z > 11) ? 1 : int'((zr >> (30 - 2 * z)) & 32'd3);
      if (code == 0 && usr) continue;
      wrOk = d[8];
      exOk = d[9];
      if (code == 3 || (code == 2 && !usr)) begin
        wrOk = 1;
        exOk = 1;
      end
      m = 0;
      ix = 6'(i);
      if ((kind == 2'd1 && !wrOk) || (kind == 2'd2 && !exOk)) begin
        f = 1;
      end else begin
        h = 1;
        rp = d[31:10];
        sz = t[9:7];
      end
      return;
    end
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) begin
        mTag[i] = '0; mData[i] = '0; mTid[i] = '0;
      end
      eValid = 0; eHit = 0; eMiss = 0; eFault = 0; eIdx = 0; eRpn = 0; eSize = 0;
    end else begin
      eValid = lookupReq;
      if (lookupReq)
        refLookup(lookupVa, lookupKind, lookupUser, procId, zoneReg,
                  eHit, eMiss, eFault, eIdx, eRpn, eSize);
      if (wrEn) begin
        if (!wrSel) begin
          mTag[wrIdx] = wrData;
          mTid[wrIdx] = wrTid;
        end else begin
          mData[wrIdx] = wrData;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done && cycles > 0) begin
      checks++;
      if ({resValid, resHit, resMiss, resFault, resIdx, resRpn, resSize} !==
          {eValid, eHit, eMiss, eFault, eIdx, eRpn, eSize}) begin
        fails++;
        $display("FAIL %s: actual v%b h%b m%b f%b idx%0d rpn%h sz%0d expected v%b h%b m%b f%b idx%0d rpn%h sz%0d",
                 curReq, resValid, resHit, resMiss, resFault, resIdx, resRpn, resSize,
                 eValid, eHit, eMiss, eFault, eIdx, eRpn, eSize);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog R2: actual no completion expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] mkTag(logic [31:0] base, int sz, bit v);
    return (base & ~32'h3FF) | (32'(sz) << 7) | (32'(v) << 6);
  endfunction

  function automatic logic [31:0] mkData(logic [31:0] rp, bit ex, bit wr, int z);
    return (rp & ~32'h3FF) | (32'(ex) << 9) | (32'(wr) << 8) | (32'(z) << 4);
  endfunction

  function automatic logic [31:0] zoneWord(int z, int code);
    int sh;
    sh = 30 - 2 * z;
    return (32'h5555_5555 & ~(32'd3 << sh)) | (32'(code) << sh);
  endfunction

  task automatic putTag(int idx, logic [31:0] w, logic [7:0] tid);
    @(negedge clk);
    wrEn = 1; wrSel = 0; wrIdx = 6'(idx); wrData = w; wrTid = tid;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic putData(int idx, logic [31:0] w);
    @(negedge clk);
    wrEn = 1; wrSel = 1; wrIdx = 6'(idx); wrData = w;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic look(logic [31:0] va, logic [1:0] kind, bit usr);
    @(negedge clk);
    lookupReq = 1; lookupVa = va; lookupKind = kind; lookupUser = usr;
    @(negedge clk);
    lookupReq = 0;
  endtask

  initial begin
    curReq = "R1";
    repeat (4) @(negedge clk);
    rstN = 1;
    look(32'h1234_5400, 2'd0, 0);                  // R1: empty table misses

    curReq = "R3";
    putTag(0, mkTag(32'h1234_5400, 0, 1), 8'd0);
    putData(0, mkData(32'hABCD_E000, 1, 1, 0));
    look(32'h1234_57FC, 2'd0, 0);                  // R3 hit

    curReq = "R2";
    repeat (3) @(negedge clk);                      // R2 result held
    look(32'h1234_5400, 2'd1, 1);

    curReq = "R4";
    look(32'h1234_5800, 2'd0, 0);                  // just past a 1 KiB page
    for (int s = 0; s < 8; s++) begin
      logic [31:0] sz;
      sz = 32'd1024 << (2 * s);
      putTag(10, mkTag(32'h8000_0000, s, 1), 8'd0);
      putData(10, mkData(32'h0040_0000, 1, 1, 0));
      look(32'h8000_0000 + sz - 32'd4, 2'd0, 0);
      look(32'h8000_0000 + sz, 2'd0, 0);
      look(32'h7FFF_FFFC, 2'd0, 0);
    end

    curReq = "R5";
    putTag(12, mkTag(32'h3000_0000, 1, 1), 8'd7);
    putData(12, mkData(32'h0012_0000, 0, 1, 0));
    procId = 8'd7; look(32'h3000_0100, 2'd0, 1);
    procId = 8'd8; look(32'h3000_0100, 2'd0, 1);
    putTag(13, mkTag(32'h3000_0000, 1, 1), 8'd0);
    putData(13, mkData(32'h0013_0000, 1, 1, 0));
    look(32'h3000_0100, 2'd0, 1);

    curReq = "R6";
    procId = 8'd7; look(32'h3000_0100, 2'd0, 1);
    putTag(41, mkTag(32'h5000_0400, 1, 1), 8'd0);
    putData(41, mkData(32'h0041_0000, 1, 1, 0));
    putTag(40, mkTag(32'h5000_0000, 5, 1), 8'd0);
    putData(40, mkData(32'h0040_0000, 1, 1, 0));
    look(32'h5000_0400, 2'd0, 0);
    putTag(40, mkTag(32'h5000_0000, 5, 0), 8'd0);   // R3 invalidate
    look(32'h5000_0400, 2'd0, 0);

    curReq = "R7";
    look(32'h5000_1000, 2'd2, 0);

    curReq = "R12";
    putTag(50, mkTag(32'h6000_0000, 1, 1), 8'd0);
    putData(50, mkData(32'h0050_0000, 1, 0, 0));
    for (int k = 0; k < 4; k++) begin
      look(32'h6000_0040, 2'(k), 0);
      look(32'h6000_0040, 2'(k), 1);
    end
    putData(50, mkData(32'h0050_0000, 0, 1, 0));
    look(32'h6000_0040, 2'd2, 0);
    look(32'h6000_0040, 2'd1, 1);

    curReq = "R8";
    putTag(30, mkTag(32'h2000_0000, 1, 1), 8'd0);
    putData(30, mkData(32'h0030_0000, 0, 0, 2));
    putTag(31, mkTag(32'h2000_0000, 1, 1), 8'd0);
    putData(31, mkData(32'h0031_0000, 1, 1, 0));
    zoneReg = zoneWord(2, 1);
    look(32'h2000_0010, 2'd1, 0);

    curReq = "R9";
    zoneReg = zoneWord(2, 0);
    look(32'h2000_0010, 2'd0, 1);
    look(32'h2000_0010, 2'd0, 0);
    look(32'h2000_0010, 2'd1, 0);

    curReq = "R10";
    zoneReg = zoneWord(2, 2);
    look(32'h2000_0010, 2'd1, 0);
    look(32'h2000_0010, 2'd1, 1);
    look(32'h2000_0010, 2'd2, 1);
    zoneReg = zoneWord(2, 3);
    look(32'h2000_0010, 2'd2, 1);
    look(32'h2000_0010, 2'd1, 1);

    curReq = "R11";
    putData(30, mkData(32'h0030_0000, 0, 0, 13));
    zoneReg = zoneWord(13, 0);
    look(32'h2000_0010, 2'd0, 1);
    look(32'h2000_0010, 2'd1, 1);
    putData(30, mkData(32'h0030_0000, 0, 0, 11));
    zoneReg = zoneWord(11, 0);
    look(32'h2000_0010, 2'd0, 1);
    putData(30, mkData(32'h0030_0000, 0, 0, 12));
    zoneReg = zoneWord(12, 0);
    look(32'h2000_0010, 2'd0, 1);

    curReq = "R6 random";
    for (int e = 0; e < 64; e++) begin
      logic [31:0] w;
      w = $urandom;
      putTag(e, mkTag({w[31:20], 20'h0} | (w & 32'h000F_FC00), int'($urandom % 8),
                      ($urandom % 4) != 0), 8'($urandom % 3));
      putData(e, $urandom);
    end
    for (int n = 0; n < 300; n++) begin
      logic [31:0] va;
      int pick;
      pick = int'($urandom % 64);
      va = mTag[pick] ^ ($urandom & 32'h0000_7FFF);
      procId = 8'($urandom % 3);
      zoneReg = $urandom;
      look(va, 2'($urandom % 4), 1'($urandom % 2));
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule